// File: doc/BRIEF.md
# Four-Way True-LRU Replacement Tracker

This block tracks the exact recency order of the four ways in every set of a four-way set-associative cache. Each set keeps a 5-bit code. The top 2 bits give the most recently used way and the next 2 bits give the second most recent way. The low bit picks the third and fourth positions from the two ways that are left. It is 0 when the lower-numbered of those two was used more recently, and 1 when the higher-numbered one was.

On each access strobe the tracker reads the indexed set's code and decodes it into an ordered list. It moves the target way to the front, re-encodes the list and writes it back at the clock edge. On a hit the target is the supplied way. On a miss the target is the least-recently-used way. That way is reported on the victim output without delay, so the cache controller can choose where to refill before the edge.

The tag compare and the data arrays sit outside this block. The decoded order of the indexed set can also be brought out. A parameter selects whether that port is driven.

Top module: `lru4_tracker`

## Requirements
- R1: After reset every set holds the order MRU-to-LRU (0,1,2,3), so the victim reported for any set is way 3.
- R2: `victim_way` equals the least-recently-used way of the set selected by `acc_set`. It follows a change of `acc_set` in the same cycle, without a clock edge.
- R3: A strobe with `acc_hit`=1 on a way at position p puts that way at position 0 and moves the ways that were at positions 0..p-1 back by one. Ways behind p keep their places. The new order is visible after the next rising clock edge. For example, (0,1,2,3) with a hit on 2 becomes (2,0,1,3).
- R4: A hit on the way already at position 0 leaves the order unchanged.
- R5: A strobe with `acc_hit`=0 takes the way at the last position (the reported victim), moves it to the front and shifts the other three back. For example, (1,2,0,3) becomes (3,1,2,0). Four misses in a row starting from reset replace ways 3, 2, 1, 0 in turn.
- R6: While `acc_valid` is 0, no set's order changes, whatever `acc_hit` and `acc_way` are.
- R7: An access changes only the set named by `acc_set`. All other sets keep their order.
- R8: `order_out` presents the selected set's order with position i in bits [2i+1:2i]. Position 0 is the most recently used way and occupies bits [1:0], and position 3, the least recently used, occupies bits [7:6]. The four fields are always a permutation of 0..3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| acc_set | input | SET_W | Set index of the access, also selects the set shown on the outputs |
| acc_valid | input | 1 | Access strobe, updates the indexed set at the clock edge |
| acc_hit | input | 1 | 1: the access hit `acc_way`; 0: miss, the victim is replaced |
| acc_way | input | 2 | Way that hit, used only when `acc_hit` is 1 |
| victim_way | output | 2 | Least-recently-used way of the indexed set |
| order_out | output | 8 | Decoded recency order of the indexed set (zero when EXPOSE_ORDER is 0) |

## Verification
`victim_way` and `order_out` are combinational from the stored code and the current `acc_set`, so they are due in the cycle where the index is driven. The bench drives inputs on the falling edge and reads these outputs one time step later. A state update is due one rising edge after the strobe. The bench therefore raises the strobe on a falling edge and drops it on the next falling edge. Only after that does it re-read the order, so each check sees exactly one update. Reset release passes through a two-stage synchronizer, so the bench waits several edges after releasing `rst_n` before the first access.

// File: rtl/lru4_pkg.sv
package lru4_pkg;
  localparam int WAYS   = 4;
  localparam int WAY_W  = 2;
  localparam int CODE_W = 2 * WAY_W + 1;

  typedef logic [WAY_W-1:0]            way_t;
  typedef logic [CODE_W-1:0]           code_t;
  // element [0] is the most recently used way, [WAYS-1] the least
  typedef logic [WAYS-1:0][WAY_W-1:0]  order_t;

  // order (0,1,2,3): front=0, second=1, remaining {2,3} with lower one newer
  localparam code_t RESET_CODE = {2'd0, 2'd1, 1'b0};
endpackage

// File: rtl/lru4_rst_sync.sv
module lru4_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/lru4_decode.sv
module lru4_decode
  import lru4_pkg::*;
(
  input  code_t  code_i,
  output order_t order_o
);
  way_t front, second, lo_way, hi_way;
  logic lo_found, hi_found;

  always_comb begin
    front    = code_i[CODE_W-1 -: WAY_W];
    second   = code_i[CODE_W-1-WAY_W -: WAY_W];
    lo_way   = '0;
    hi_way   = '0;
    lo_found = 1'b0;
    hi_found = 1'b0;
    // smallest way absent from the two stored indices
    for (int w = 0; w < WAYS; w++) begin
      if (!lo_found && (way_t'(w) != front) && (way_t'(w) != second)) begin
        lo_way   = way_t'(w);
        lo_found = 1'b1;
      end
    end
    // largest way absent from the two stored indices
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (!hi_found && (way_t'(w) != front) && (way_t'(w) != second)) begin
        hi_way   = way_t'(w);
        hi_found = 1'b1;
      end
    end
    order_o[0] = front;
    order_o[1] = second;
    order_o[2] = code_i[0] ? hi_way : lo_way;
    order_o[3] = code_i[0] ? lo_way : hi_way;
  end
endmodule

// File: rtl/lru4_promote.sv
module lru4_promote
  import lru4_pkg::*;
(
  input  order_t cur_i,
  input  way_t   target_i,
  output order_t nxt_o,
  output code_t  nxt_code_o
);
  int unsigned pos;

  always_comb begin
    pos = WAYS - 1;
    for (int i = 0; i < WAYS; i++) begin
      if (cur_i[i] == target_i) pos = i;
    end
    nxt_o[0] = target_i;
    for (int i = 1; i < WAYS; i++) begin
      nxt_o[i] = (i <= pos) ? cur_i[i-1] : cur_i[i];
    end
    nxt_code_o = {nxt_o[0], nxt_o[1], (nxt_o[2] > nxt_o[3])};
  end
endmodule

// File: rtl/lru4_state_bank.sv
module lru4_state_bank
  import lru4_pkg::*;
#(
  parameter int NUM_SETS = 16,
  parameter int SET_W    = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SET_W-1:0] set_i,
  input  logic             wr_en_i,
  input  code_t            wr_code_i,
  output code_t            rd_code_o
);
  code_t code_q [NUM_SETS];
  code_t code_d [NUM_SETS];

  for (genvar s = 0; s < NUM_SETS; s++) begin : g_set
    logic set_en;
    assign set_en = wr_en_i && (set_i == SET_W'(s));

    always_comb begin
      code_d[s] = code_q[s];
      if (set_en) code_d[s] = wr_code_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        code_q[s] <= RESET_CODE;
      end else if (set_en) begin
        code_q[s] <= code_d[s];
      end
    end
  end

  always_comb begin
    rd_code_o = RESET_CODE;
    if ({1'b0, set_i} < (SET_W+1)'(NUM_SETS)) rd_code_o = code_q[set_i];
  end
endmodule

// File: rtl/lru4_tracker.sv
module lru4_tracker
  import lru4_pkg::*;
#(
  parameter int NUM_SETS     = 16,
  parameter bit EXPOSE_ORDER = 1'b1,
  localparam int SET_W       = (NUM_SETS > 1) ? $clog2(NUM_SETS) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SET_W-1:0] acc_set,
  input  logic             acc_valid,
  input  logic             acc_hit,
  input  logic [1:0]       acc_way,
  output logic [1:0]       victim_way,
  output logic [7:0]       order_out
);
  logic   core_rst_n;
  code_t  cur_code, nxt_code;
  order_t cur_order, nxt_order;
  way_t   target;
  logic [7:0] cur_order_flat;

  lru4_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (core_rst_n)
  );

  lru4_state_bank #(.NUM_SETS(NUM_SETS), .SET_W(SET_W)) u_bank (
    .clk       (clk),
    .rst_n     (core_rst_n),
    .set_i     (acc_set),
    .wr_en_i   (acc_valid),
    .wr_code_i (nxt_code),
    .rd_code_o (cur_code)
  );

  lru4_decode u_dec (
    .code_i  (cur_code),
    .order_o (cur_order)
  );

  assign victim_way = cur_order[WAYS-1];
  assign target     = acc_hit ? acc_way : victim_way;

  lru4_promote u_prom (
    .cur_i      (cur_order),
    .target_i   (target),
    .nxt_o      (nxt_order),
    .nxt_code_o (nxt_code)
  );

  assign cur_order_flat = cur_order;

  if (EXPOSE_ORDER) begin : g_order
    assign order_out = cur_order_flat;
  end else begin : g_no_order
    assign order_out = '0;
  end
endmodule

// File: rtl/lru4_tracker_chk.sv
module lru4_tracker_chk #(
  parameter int SET_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             core_rst_n,
  input logic [SET_W-1:0] acc_set,
  input logic             acc_valid,
  input logic             acc_hit,
  input logic [1:0]       acc_way,
  input logic [1:0]       victim_way,
  input logic [7:0]       cur_order
);
  logic [3:0] seen_mask;
  always_comb begin
    seen_mask = '0;
    for (int i = 0; i < 4; i++) seen_mask[cur_order[2*i +: 2]] = 1'b1;
  end

  p_hit_front_r3: assert property (@(posedge clk) disable iff (!rst_n || !core_rst_n)
    (acc_valid && acc_hit) |=>
      ((acc_set != $past(acc_set)) || (cur_order[1:0] == $past(acc_way))));

  p_mru_noop_r4: assert property (@(posedge clk) disable iff (!rst_n || !core_rst_n)
    (acc_valid && acc_hit && (acc_way == cur_order[1:0])) |=>
      ((acc_set != $past(acc_set)) || $stable(cur_order)));

  p_miss_front_r5: assert property (@(posedge clk) disable iff (!rst_n || !core_rst_n)
    (acc_valid && !acc_hit) |=>
      ((acc_set != $past(acc_set)) || (cur_order[1:0] == $past(victim_way))));

  p_idle_hold_r6: assert property (@(posedge clk) disable iff (!rst_n || !core_rst_n)
    (!acc_valid) |=> ((acc_set != $past(acc_set)) || $stable(cur_order)));

  p_order_perm_r8: assert property (@(posedge clk) disable iff (!rst_n || !core_rst_n)
    $countones(seen_mask) == 4);
endmodule

bind lru4_tracker lru4_tracker_chk #(.SET_W(SET_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .core_rst_n (core_rst_n),
  .acc_set    (acc_set),
  .acc_valid  (acc_valid),
  .acc_hit    (acc_hit),
  .acc_way    (acc_way),
  .victim_way (victim_way),
  .cur_order  (cur_order_flat)
);

// File: tb/sim_lru4_tracker.sv
module sim_lru4_tracker;
  localparam int CLK_PERIOD = 10;
  localparam int NSETS      = 16;
  localparam int SW         = 4;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [SW-1:0] acc_set;
  logic          acc_valid, acc_hit;
  logic [1:0]    acc_way;
  logic [1:0]    victim_way;
  logic [7:0]    order_out;

  int n_checks = 0;
  int n_fail   = 0;
  int mdl [NSETS][4];

  always #(CLK_PERIOD/2) clk = ~clk;

  lru4_tracker #(.NUM_SETS(NSETS), .EXPOSE_ORDER(1'b1)) u0 (
    .clk(clk), .rst_n(rst_n), .acc_set(acc_set), .acc_valid(acc_valid),
    .acc_hit(acc_hit), .acc_way(acc_way), .victim_way(victim_way),
    .order_out(order_out)
  );

  function automatic logic [7:0] pack_order(int s);
    logic [7:0] v;
    for (int i = 0; i < 4; i++) v[2*i +: 2] = 2'(mdl[s][i]);
    return v;
  endfunction

  function automatic void mdl_promote(int s, int w);
    int p = 3;
    for (int i = 0; i < 4; i++) if (mdl[s][i] == w) p = i;
    for (int i = p; i > 0; i--) mdl[s][i] = mdl[s][i-1];
    mdl[s][0] = w;
  endfunction

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // read selected set without a strobe; called just after a falling edge
  task automatic check_set(int s, string req);
    acc_valid = 1'b0;
    acc_set   = SW'(s);
    #1;
    check(req, order_out, pack_order(s));
    check(req, {6'd0, victim_way}, 8'(mdl[s][3]));
  endtask

  // one strobed access: driven at a falling edge, victim checked before the edge
  task automatic access(int s, bit hit, int w);
    int tgt;
    acc_set   = SW'(s);
    acc_valid = 1'b1;
    acc_hit   = hit;
    acc_way   = 2'(w);
    #1;
    check("R2 victim before edge", {6'd0, victim_way}, 8'(mdl[s][3]));
    tgt = hit ? w : mdl[s][3];
    @(posedge clk);
    mdl_promote(s, tgt);
    @(negedge clk);
    acc_valid = 1'b0;
  endtask

  task automatic t_reset;
    for (int s = 0; s < NSETS; s++) check_set(s, "R1 reset order");
  endtask

  task automatic t_example_chain;
    access(5, 1'b1, 2);
    check_set(5, "R3 hit 2 -> (2,0,1,3)");
    check("R3 literal", order_out, {2'd3, 2'd1, 2'd0, 2'd2});
    access(5, 1'b1, 1);
    check_set(5, "R3 hit 1 -> (1,2,0,3)");
    check("R3 literal", order_out, {2'd3, 2'd0, 2'd2, 2'd1});
    access(5, 1'b0, 0);
    check_set(5, "R5 miss -> (3,1,2,0)");
    check("R5 literal", order_out, {2'd0, 2'd2, 2'd1, 2'd3});
    access(5, 1'b1, 3);
    check_set(5, "R4 hit on front unchanged");
    check("R4 literal", order_out, {2'd0, 2'd2, 2'd1, 2'd3});
  endtask

  task automatic t_isolation;
    for (int s = 0; s < NSETS; s++) if (s != 5) check_set(s, "R7 other sets untouched");
  endtask

  task automatic t_idle;
    acc_set = 4'd5; acc_valid = 1'b0; acc_hit = 1'b1; acc_way = 2'd0;
    repeat (4) @(negedge clk);
    acc_hit = 1'b0;
    repeat (3) @(negedge clk);
    check_set(5, "R6 no strobe no change");
  endtask

  task automatic t_miss_rotation;
    for (int k = 0; k < 4; k++) begin
      acc_set = 4'd9; #1;
      check("R5 victim rotation", {6'd0, victim_way}, 8'(3 - k));
      access(9, 1'b0, 0);
    end
    check_set(9, "R5 four misses back to reset order");
    check("R5 literal", order_out, {2'd3, 2'd2, 2'd1, 2'd0});
  endtask

  task automatic t_comb_victim;
    acc_valid = 1'b0;
    acc_set = 4'd5; #1;
    check("R2 victim set 5", {6'd0, victim_way}, 8'(mdl[5][3]));
    acc_set = 4'd12; #1;
    check("R2 victim follows index same cycle", {6'd0, victim_way}, 8'd3);
  endtask

  task automatic t_stream;
    logic [15:0] lfsr = 16'hACE1;
    for (int n = 0; n < 300; n++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      access(int'(lfsr[1:0]), lfsr[4], int'(lfsr[3:2]));
      check_set(int'(lfsr[1:0]), "R3/R5 mixed stream");
    end
    for (int s = 0; s < NSETS; s++) check_set(s, "R7/R8 all sets after stream");
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    for (int s = 0; s < NSETS; s++) for (int i = 0; i < 4; i++) mdl[s][i] = i;
    rst_n = 1'b0; acc_set = '0; acc_valid = 1'b0; acc_hit = 1'b0; acc_way = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_example_chain();
    t_isolation();
    t_idle();
    t_miss_rotation();
    t_comb_victim();
    t_stream();
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule